// File: doc/BRIEF.md
# Vector Compare and Mask Unit

This block sets a per-element predicate mask for a vector datapath. It walks one element per clock through a vector of signed integers. It compares each element either with the matching element of a second vector or with a single scalar, and records a 1 or a 0 for that element in a mask register. The mask is `NELEM` bits wide, one bit per element.

Beside the compare, the unit offers the small operations that go with a mask:

- counting the set bits below the vector length into a scalar result;
- forcing every mask bit to 1;
- copying the mask to a scalar, or loading it from one;
- writing an index vector whose elements step by a scalar stride.

Vector operands are read through an element read port. The bench or the surrounding datapath answers that port in the same cycle, with data for the element named by `rd_idx`. Index vectors leave through an element write port.

A controller starts an operation when `start` is high and the unit is idle. Element-serial operations keep `busy` high while elements are processed. Single-cycle operations complete at the start edge without raising `busy`.

Top module: `vcmp_mask_unit`

## Requirements
- R1: The `cond` input selects the element test `a ? b`, with both operands treated as signed: 0 = equal, 1 = not equal, 2 = greater than, 3 = less than, 4 = greater or equal, 5 = less or equal. Codes 6 and 7 never hold. A mask bit is 1 where the test holds and 0 where it fails.
- R2: Op 0 compares `elem_a` with `elem_b`. Op 1 compares `elem_a` with the scalar operand, which is captured from `scalar_in` at the start edge and used for every element even if `scalar_in` later changes.
- R3: The effective length is `vlen`, clamped to `NELEM`. A compare (op 0 or 1) leaves every mask bit at or above the effective length at 0.
- R4: Op 2 puts on `scalar_out` the number of 1 bits of the mask below the effective length. Bits at or above the effective length are not counted.
- R5: Op 3 sets every mask bit to 1.
- R6: Op 4 copies the mask, zero-extended, to `scalar_out`. Op 5 loads the mask from the low `NELEM` bits of `scalar_in`.
- R7: Op 6 writes, for each i below the effective length, the value i times the captured scalar (modulo 2^DW) to element i through `vwr_en`/`vwr_idx`/`vwr_data`. Elements at or above the effective length are not written.
- R8: For ops 0, 1 and 6 with a nonzero effective length, `busy` is high for exactly that many cycles, starting the cycle after the start edge. Results are valid once `busy` is low. Ops 2 to 5, and vector ops of length 0, never raise `busy`; their result is visible in the cycle after the start edge.
- R9: A `start` while `busy` is high is ignored: the running operation and its results are unaffected.
- R10: Op 7 changes neither the mask nor `scalar_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch an operation when idle |
| op | input | 3 | Operation code (R2 to R7, R10) |
| cond | input | 3 | Compare condition code (R1) |
| vlen | input | $clog2(NELEM+1) | Requested vector length |
| scalar_in | input | SW | Scalar operand: compare value, stride or mask source |
| elem_a | input | DW | First source element at `rd_idx` |
| elem_b | input | DW | Second source element at `rd_idx` |
| busy | output | 1 | Element-serial operation in progress |
| rd_idx | output | $clog2(NELEM) | Element index being read |
| vwr_en | output | 1 | Index-vector element write strobe |
| vwr_idx | output | $clog2(NELEM) | Index-vector element address |
| vwr_data | output | DW | Index-vector element value |
| scalar_out | output | SW | Scalar result of count or mask copy |
| mask_out | output | NELEM | Current mask register |

## Verification
The hardest case to reach is a second `start` landing in the middle of a running compare. That pulse carries an operation which would visibly rewrite the mask: set-all or load-from-scalar. The bench raises it deliberately a few cycles into a full-length compare, then checks that the final mask equals the compare result alone.

Each run also drives an inverted value onto `scalar_in` as soon as the start pulse ends. This exposes any use of the live scalar instead of the captured one. Random lengths above `NELEM` and equal to 0 cover the clamp and the empty case.

// File: rtl/vcm_pkg.sv
package vcm_pkg;

  typedef enum logic [2:0] {
    OP_CMP_VV = 3'd0,
    OP_CMP_VS = 3'd1,
    OP_POPC   = 3'd2,
    OP_MSET   = 3'd3,
    OP_MTOS   = 3'd4,
    OP_MFROMS = 3'd5,
    OP_INDEX  = 3'd6,
    OP_RSV    = 3'd7
  } vop_e;

  typedef enum logic [2:0] {
    CC_EQ = 3'd0,
    CC_NE = 3'd1,
    CC_GT = 3'd2,
    CC_LT = 3'd3,
    CC_GE = 3'd4,
    CC_LE = 3'd5
  } vcond_e;

endpackage

// File: rtl/vcm_elem_cmp.sv
module vcm_elem_cmp
  import vcm_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [2:0]    cond,
  output logic          hit
);

  logic signed [DW-1:0] sa, sb;
  logic                 eq, lt;

  assign sa = a;
  assign sb = b;
  assign eq = (sa == sb);
  assign lt = (sa < sb);

  always_comb begin
    case (cond)
      CC_EQ:   hit = eq;
      CC_NE:   hit = !eq;
      CC_GT:   hit = !lt && !eq;
      CC_LT:   hit = lt;
      CC_GE:   hit = !lt;
      CC_LE:   hit = lt || eq;
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/vcm_popcnt.sv
module vcm_popcnt #(
  parameter int NELEM = 64,
  localparam int VLW  = $clog2(NELEM + 1)
) (
  input  logic [NELEM-1:0] bits,
  input  logic [VLW-1:0]   len,
  output logic [VLW-1:0]   count
);

  always_comb begin
    count = '0;
    for (int i = 0; i < NELEM; i++) begin
      if (i < int'(len) && bits[i]) count = count + 1'b1;
    end
  end

endmodule

// File: rtl/vcm_idx_gen.sv
module vcm_idx_gen #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [DW-1:0] stride,
  output logic [DW-1:0] value
);

  logic [DW-1:0] acc_q, acc_d;
  logic          acc_en;

  assign acc_en = clr || step;

  always_comb begin
    acc_d = acc_q;
    if (clr)       acc_d = '0;
    else if (step) acc_d = acc_q + stride;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign value = acc_q;

  // consecutive written values differ by exactly the stride
  assert_index_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step && !clr |=> acc_q == $past(acc_q) + $past(stride));

endmodule

// File: rtl/vcmp_mask_unit.sv
module vcmp_mask_unit
  import vcm_pkg::*;
#(
  parameter int NELEM = 64,
  parameter int DW    = 64,
  parameter int SW    = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [2:0]                 op,
  input  logic [2:0]                 cond,
  input  logic [$clog2(NELEM+1)-1:0] vlen,
  input  logic [SW-1:0]              scalar_in,
  input  logic [DW-1:0]              elem_a,
  input  logic [DW-1:0]              elem_b,
  output logic                       busy,
  output logic [$clog2(NELEM)-1:0]   rd_idx,
  output logic                       vwr_en,
  output logic [$clog2(NELEM)-1:0]   vwr_idx,
  output logic [DW-1:0]              vwr_data,
  output logic [SW-1:0]              scalar_out,
  output logic [NELEM-1:0]           mask_out
);

  localparam int VLW = $clog2(NELEM + 1);
  localparam int IW  = $clog2(NELEM);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  // state
  logic             run_q, run_d;
  vop_e             op_q, op_d;
  logic [2:0]       cond_q, cond_d;
  logic [VLW-1:0]   len_q, len_d;
  logic [SW-1:0]    scal_q, scal_d;
  logic [VLW-1:0]   idx_q, idx_d;
  logic [NELEM-1:0] mask_q, mask_d;
  logic [SW-1:0]    sout_q, sout_d;

  logic             accept, is_cmp, hit;
  logic [VLW-1:0]   len_eff, pop;
  logic [DW-1:0]    cmp_b;

  assign accept  = start && !run_q;
  assign len_eff = (int'(vlen) > NELEM) ? VLW'(NELEM) : vlen;
  assign is_cmp  = (op_q == OP_CMP_VV) || (op_q == OP_CMP_VS);
  assign cmp_b   = (op_q == OP_CMP_VS) ? scal_q[DW-1:0] : elem_b;

  vcm_elem_cmp #(.DW(DW)) u_cmp (
    .a(elem_a), .b(cmp_b), .cond(cond_q), .hit(hit)
  );

  vcm_popcnt #(.NELEM(NELEM)) u_pop (
    .bits(mask_q), .len(len_eff), .count(pop)
  );

  vcm_idx_gen #(.DW(DW)) u_idx (
    .clk(clk), .rst_n(rst_i_n), .clr(accept),
    .step(run_q && op_q == OP_INDEX),
    .stride(scal_q[DW-1:0]), .value(vwr_data)
  );

  // next state
  always_comb begin
    run_d  = run_q;
    op_d   = op_q;
    cond_d = cond_q;
    len_d  = len_q;
    scal_d = scal_q;
    idx_d  = idx_q;
    mask_d = mask_q;
    sout_d = sout_q;
    if (accept) begin
      op_d   = vop_e'(op);
      cond_d = cond;
      len_d  = len_eff;
      scal_d = scalar_in;
      idx_d  = '0;
      case (vop_e'(op))
        OP_CMP_VV, OP_CMP_VS: begin
          mask_d = '0;
          run_d  = (len_eff != '0);
        end
        OP_INDEX:  run_d  = (len_eff != '0);
        OP_POPC:   sout_d = SW'(pop);
        OP_MSET:   mask_d = '1;
        OP_MTOS:   sout_d = SW'(mask_q);
        OP_MFROMS: mask_d = scalar_in[NELEM-1:0];
        default:   ;
      endcase
    end else if (run_q) begin
      if (is_cmp) mask_d[idx_q[IW-1:0]] = hit;
      idx_d = idx_q + 1'b1;
      if (idx_q == len_q - 1'b1) run_d = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      run_q  <= 1'b0;
      op_q   <= OP_RSV;
      cond_q <= '0;
      len_q  <= '0;
      scal_q <= '0;
      idx_q  <= '0;
      mask_q <= '0;
      sout_q <= '0;
    end else begin
      run_q  <= run_d;
      mask_q <= mask_d;
      sout_q <= sout_d;
      if (accept || run_q) idx_q <= idx_d;
      if (accept) begin
        op_q   <= op_d;
        cond_q <= cond_d;
        len_q  <= len_d;
        scal_q <= scal_d;
      end
    end
  end

  assign busy       = run_q;
  assign rd_idx     = idx_q[IW-1:0];
  assign vwr_en     = run_q && (op_q == OP_INDEX);
  assign vwr_idx    = idx_q[IW-1:0];
  assign scalar_out = sout_q;
  assign mask_out   = mask_q;

  function automatic logic [NELEM-1:0] below_len(input logic [VLW-1:0] l);
    for (int i = 0; i < NELEM; i++) below_len[i] = (i < int'(l));
  endfunction

  assert_tail_clear_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    $fell(run_q) && is_cmp |-> (mask_q & ~below_len(len_q)) == '0);

  assert_write_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    vwr_en |-> busy && (idx_q < len_q));

  assert_first_index_zero_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    vwr_en && idx_q == '0 |-> vwr_data == '0);

  assert_scalar_held_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    run_q && start |=> $stable(scal_q) && $stable(op_q));

  assert_mask_set_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    accept && op == OP_MSET |=> &mask_q);

  assert_rsv_noop_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    accept && op == OP_RSV |=> $stable(mask_q) && $stable(sout_q));

endmodule

// File: tb/sim_vcmp_mask_unit.sv
module sim_vcmp_mask_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 64;
  localparam int DW = 64;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          rst_n, start, busy, vwr_en;
  logic [2:0]    op, cond;
  logic [6:0]    vlen;
  logic [63:0]   scalar_in, scalar_out, mask_out, vwr_data, elem_a, elem_b;
  logic [5:0]    rd_idx, vwr_idx;
  logic [63:0]   va [NE];
  logic [63:0]   vb [NE];
  logic [63:0]   vw [NE];

  assign elem_a = va[rd_idx];
  assign elem_b = vb[rd_idx];
  always @(posedge clk) if (vwr_en) vw[vwr_idx] <= vwr_data;

  vcmp_mask_unit #(.NELEM(NE), .DW(DW), .SW(64)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .cond(cond),
    .vlen(vlen), .scalar_in(scalar_in), .elem_a(elem_a), .elem_b(elem_b),
    .busy(busy), .rd_idx(rd_idx), .vwr_en(vwr_en), .vwr_idx(vwr_idx),
    .vwr_data(vwr_data), .scalar_out(scalar_out), .mask_out(mask_out)
  );

  int checks = 0, fails = 0;
  logic [63:0] exp_mask, exp_sout;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit ref_cond(input logic [63:0] a, input logic [63:0] b, input int c);
    case (c)
      0: return $signed(a) == $signed(b);
      1: return $signed(a) != $signed(b);
      2: return $signed(a) >  $signed(b);
      3: return $signed(a) <  $signed(b);
      4: return $signed(a) >= $signed(b);
      5: return $signed(a) <= $signed(b);
      default: return 1'b0;
    endcase
  endfunction

  function automatic int eff(input int l);
    return (l > NE) ? NE : l;
  endfunction

  function automatic logic [63:0] ref_cmp(input bit vs, input int c, input int l, input logic [63:0] s);
    logic [63:0] m = '0;
    for (int i = 0; i < eff(l); i++) m[i] = ref_cond(va[i], vs ? s : vb[i], c);
    return m;
  endfunction

  function automatic logic [63:0] ref_pop(input logic [63:0] m, input int l);
    int n = 0;
    for (int i = 0; i < eff(l); i++) n += int'(m[i]);
    return 64'(n);
  endfunction

  // launches one op, scrambles scalar_in after the start edge, counts busy cycles
  task automatic run_op(input int o, input int c, input int l, input logic [63:0] s, output int bc);
    @(negedge clk);
    start = 1'b1; op = 3'(o); cond = 3'(c); vlen = 7'(l); scalar_in = s;
    @(negedge clk);
    start = 1'b0; scalar_in = ~s;
    bc = 0;
    while (busy) begin bc++; @(negedge clk); end
  endtask

  task automatic fill_vectors(input bool_eq_bias);
    for (int i = 0; i < NE; i++) begin
      va[i] = {$urandom, $urandom} >>> ($urandom % 60);
      if ($urandom % 3 == 0) va[i] = -va[i];
      vb[i] = (bool_eq_bias && ($urandom % 3 == 0)) ? va[i] : {$urandom, $urandom} >>> ($urandom % 60);
    end
  endtask

  task automatic check_vec_op(input int o, input int c, input int l, input logic [63:0] s, input string tag);
    int bc, L;
    logic [63:0] m;
    L = eff(l);
    for (int i = 0; i < NE; i++) vw[i] = 64'hDEAD_BEEF_0000_0000 | 64'(i);
    run_op(o, c, l, s, bc);
    chk(bc == ((o == 0 || o == 1 || o == 6) ? L : 0), "R8 busy cycles", 64'(bc), 64'(L));
    if (o == 0 || o == 1) begin
      exp_mask = ref_cmp(o == 1, c, l, s);
      chk(mask_out == exp_mask, tag, mask_out, exp_mask);
    end else if (o == 6) begin
      bit ok = 1'b1;
      for (int i = 0; i < NE; i++) begin
        m = (i < L) ? 64'(i) * s : (64'hDEAD_BEEF_0000_0000 | 64'(i));
        if (vw[i] !== m) ok = 1'b0;
      end
      chk(ok, "R7 index vector", vw[L > 0 ? L-1 : 0], (L > 0) ? 64'(L-1) * s : vw[0]);
    end else if (o == 2) begin
      exp_sout = ref_pop(exp_mask, l);
      chk(scalar_out == exp_sout, "R4 popcount", scalar_out, exp_sout);
    end else if (o == 3) begin
      exp_mask = '1;
      chk(mask_out == exp_mask, "R5 mask set", mask_out, exp_mask);
    end else if (o == 4) begin
      exp_sout = exp_mask;
      chk(scalar_out == exp_sout, "R6 mask to scalar", scalar_out, exp_sout);
    end else if (o == 5) begin
      exp_mask = s;
      chk(mask_out == exp_mask, "R6 mask from scalar", mask_out, exp_mask);
    end else begin
      chk(mask_out == exp_mask && scalar_out == exp_sout, "R10 reserved op", mask_out, exp_mask);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; start = 1'b0; op = '0; cond = '0; vlen = '0; scalar_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && mask_out == 0 && scalar_out == 0 && !vwr_en, "R8 reset state", mask_out, 64'd0);
    exp_mask = '0; exp_sout = '0;

    // directed: equal vectors, all six conditions plus unused codes
    for (int i = 0; i < NE; i++) begin va[i] = 64'(i) - 64'd20; vb[i] = va[i]; end
    vb[3] = 64'd100; vb[10] = -64'd100;
    for (int c = 0; c < 8; c++) check_vec_op(0, c, 64, 0, "R1 vector compare");
    // scalar compare with negative scalar, length clamped to NE
    check_vec_op(1, 2, 100, -64'sd5, "R2 scalar compare");
    check_vec_op(1, 5, 64, 64'd7, "R2 scalar compare held");
    // short length clears tail bits
    check_vec_op(3, 0, 0, 0, "R5");
    check_vec_op(0, 0, 9, 0, "R3 tail cleared");
    check_vec_op(0, 1, 0, 0, "R3 zero length clears mask");
    check_vec_op(3, 0, 0, 0, "R5");
    check_vec_op(2, 0, 17, 0, "R4");
    check_vec_op(2, 0, 127, 0, "R4");
    check_vec_op(5, 0, 0, 64'hF0F0_1234_8000_0001, "R6");
    check_vec_op(4, 0, 0, 0, "R6");
    check_vec_op(7, 3, 40, 64'h55, "R10");
    check_vec_op(6, 0, 64, -64'sd3, "R7");
    check_vec_op(6, 0, 5, 64'd11, "R7");

    // start during busy is ignored
    begin
      int bc;
      exp_mask = ref_cmp(1'b0, 3, 64, 0);
      @(negedge clk);
      start = 1'b1; op = 3'd0; cond = 3'd3; vlen = 7'd64;
      @(negedge clk); start = 1'b0;
      repeat (5) @(negedge clk);
      start = 1'b1; op = 3'd3;
      @(negedge clk); op = 3'd5; scalar_in = 64'h1234;
      @(negedge clk); start = 1'b0;
      bc = 0;
      while (busy) begin bc++; @(negedge clk); end
      chk(mask_out == exp_mask, "R9 start while busy ignored", mask_out, exp_mask);
      chk(bc == 64 - 7, "R9 busy length unchanged", 64'(bc), 64'd57);
    end

    // random
    for (int n = 0; n < 60; n++) begin
      int o, c, l;
      logic [63:0] s;
      fill_vectors(1'b1);
      o = $urandom % 8; c = $urandom % 8; l = $urandom % 80;
      s = ($urandom % 2) ? va[$urandom % NE] : {$urandom, $urandom};
      check_vec_op(o, c, l, s, "R1 R2 R3 random compare");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule